// File: doc/BRIEF.md
# Nibble-Bus Data RAM With Status Characters

A data-memory slave that sits on a shared 4-bit multiplexed bus and follows an eight-phase instruction cycle (A1, A2, A3, M1, M2, X1, X2, X3). The processor raises a sync pulse during A1, and the block counts the remaining phases from it. It holds four registers. Each register has sixteen directly addressed main characters and four status characters of four bits each, 320 bits in total. It also has a 4-bit output port held in a latch.

The processor first sends an address command. This command latches an 8-bit address over two execute phases. The top two bits of the address pick the chip, the next two pick the register, and the low four pick the main character. Later commands read or write the addressed main character, read or write one of the four status characters of the addressed register, or load the output port. A command counts only when the bank-select line is high during M2. The three-state bus is modelled as a separate input, output and output-enable. The block raises the enable only in X2 of a selected read.

Top module: `nibble_ram`

## Requirements
- R1: `sync_i` high marks the current cycle as A1, and the phases A2, A3, M1, M2, X1, X2, X3 follow on successive clocks. A new sync restarts at A1 from any phase. Before the first sync after reset, every bus activity is ignored.
- R2: The command opcode is taken from `bus_i` in M2 only when `bank_sel_i` is high. If the bank is low in M2, that cycle writes nothing, drives nothing and leaves the address unchanged.
- R3: Opcode 0x0 is the address command. `bus_i` in X2 gives address bits [7:4] and `bus_i` in X3 gives bits [3:0]. Bits [7:6] must equal `CHIP_ID` for later data commands to act. Bits [5:4] give the register and bits [3:0] give the main character.
- R4: Opcode 0x1 writes the X2 nibble into the addressed main character.
- R5: Opcode 0x2 drives the addressed main character on `bus_o` with `bus_oe_o` high, during X2 only.
- R6: Opcode 0x4+n writes the X2 nibble into status character n (n = 0..3) of the addressed register. Opcode 0x8+n reads that character in X2. The main-character field of the address plays no part. Status and main storage never alias.
- R7: Opcode 0x3 loads the X2 nibble into `port_o`. The value holds until the next accepted port write or reset.
- R8: `bus_oe_o` is low in every phase other than X2 of a selected read. While it is low, `bus_o` is 0.
- R9: When address bits [7:6] differ from `CHIP_ID`, data commands (0x1 to 0xB) change nothing and drive nothing.
- R10: Reset clears all main and status characters, the port latch, the address (to 0) and the phase lock.
- R11: Opcodes 0xC to 0xF have no effect on storage, port or bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | High during phase A1 |
| bank_sel_i | input | 1 | Bank select, sampled in M2 |
| bus_i | input | 4 | Nibble bus as seen by the block |
| bus_o | output | 4 | Nibble driven by the block, 0 when not driving |
| bus_oe_o | output | 1 | Bus drive enable (three-state control) |
| port_o | output | 4 | Output port latch |

## Verification
The hardest case to reach is a command that arrives after the block has been deselected in one of two ways: bank select was low in M2, or the latched address names another chip. In either case the storage must stay untouched, and that can only be seen from the ports by a later selected read. The stimulus therefore writes known values first. It then sends reads and writes with the bank low and with a mismatched chip field, re-addresses the chip, and reads every affected main and status character back. A sync pulse cut short in mid-cycle, and bus traffic sent before any sync, test the phase lock the same way.

// File: rtl/nibble_ram_pkg.sv
package nibble_ram_pkg;
  typedef enum logic [2:0] {
    PH_A1, PH_A2, PH_A3, PH_M1, PH_M2, PH_X1, PH_X2, PH_X3
  } phase_e;

  localparam logic [3:0] OP_ADDR    = 4'h0;
  localparam logic [3:0] OP_WR_MAIN = 4'h1;
  localparam logic [3:0] OP_RD_MAIN = 4'h2;
  localparam logic [3:0] OP_WR_PORT = 4'h3;

  typedef struct packed {
    logic       set_addr;
    logic       wr_main;
    logic       rd_main;
    logic       wr_stat;
    logic       rd_stat;
    logic       wr_port;
    logic [1:0] stat_idx;
  } cmd_t;

  function automatic cmd_t decode_op(logic [3:0] op);
    cmd_t c;
    c          = '0;
    c.stat_idx = op[1:0];
    unique case (op[3:2])
      2'b00: begin
        c.set_addr = (op == OP_ADDR);
        c.wr_main  = (op == OP_WR_MAIN);
        c.rd_main  = (op == OP_RD_MAIN);
        c.wr_port  = (op == OP_WR_PORT);
      end
      2'b01:   c.wr_stat = 1'b1;
      2'b10:   c.rd_stat = 1'b1;
      default: ;  // reserved
    endcase
    return c;
  endfunction
endpackage

// File: rtl/nibble_ram_phase.sv
module nibble_ram_phase
  import nibble_ram_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sync_i,
  output phase_e phase_o,
  output logic   valid_o
);
  phase_e ph_q;
  logic   locked_q;

  assign phase_o = sync_i ? PH_A1 : ph_q;
  assign valid_o = sync_i | locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_A1;
      locked_q <= 1'b0;
    end else if (valid_o) begin
      ph_q     <= phase_e'(phase_o + 3'd1);
      locked_q <= 1'b1;
    end
  end

  AST_A2_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (sync_i || phase_o == PH_A2)); // R1
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R1
endmodule

// File: rtl/nibble_ram_ctrl.sv
module nibble_ram_ctrl
  import nibble_ram_pkg::*;
#(
  parameter int unsigned DATA_W  = 4,
  parameter int unsigned REG_W   = 2,
  parameter int unsigned CHAR_W  = 4,
  parameter int unsigned CHIP_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              valid_i,
  input  logic              bank_sel_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              wr_main_o,
  output logic              wr_stat_o,
  output logic              wr_port_o,
  output logic              rd_main_o,
  output logic              rd_stat_o,
  output logic [1:0]        stat_idx_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [CHAR_W-1:0] char_o
);
  localparam int unsigned ADDR_W = 2 * DATA_W;
  localparam int unsigned CHIP_W = ADDR_W - REG_W - CHAR_W;

  cmd_t              cmd_q;
  logic              act_q;
  logic [DATA_W-1:0] hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic              in_m2, in_x2, in_x3, hit, sel;

  assign in_m2 = valid_i && phase_i == PH_M2;
  assign in_x2 = valid_i && phase_i == PH_X2;
  assign in_x3 = valid_i && phase_i == PH_X3;
  assign hit   = addr_q[ADDR_W-1 -: CHIP_W] == CHIP_W'(CHIP_ID);
  assign sel   = act_q & hit & in_x2;

  assign wr_main_o  = sel & cmd_q.wr_main;
  assign wr_stat_o  = sel & cmd_q.wr_stat;
  assign wr_port_o  = sel & cmd_q.wr_port;
  assign rd_main_o  = sel & cmd_q.rd_main;
  assign rd_stat_o  = sel & cmd_q.rd_stat;
  assign stat_idx_o = cmd_q.stat_idx;
  assign reg_o      = addr_q[CHAR_W +: REG_W];
  assign char_o     = addr_q[CHAR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      act_q  <= 1'b0;
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      if (in_m2) begin
        act_q <= bank_sel_i;
        cmd_q <= decode_op(bus_i);
      end
      if (in_x2 && act_q && cmd_q.set_addr) hi_q <= bus_i;
      if (in_x3 && act_q && cmd_q.set_addr) addr_q <= {hi_q, bus_i};
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_main_o, wr_stat_o, wr_port_o, rd_main_o, rd_stat_o})); // R11
  AST_ADDR_ONLY_X3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_q) |-> $past(phase_i) == PH_X3); // R3
endmodule

// File: rtl/nibble_ram_store.sv
module nibble_ram_store #(
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned NUM_REGS   = 4,
  parameter int unsigned MAIN_CHARS = 16,
  parameter int unsigned STAT_CHARS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_main_i,
  input  logic                           wr_stat_i,
  input  logic                           wr_port_i,
  input  logic [$clog2(NUM_REGS)-1:0]    reg_i,
  input  logic [$clog2(MAIN_CHARS)-1:0]  char_i,
  input  logic [$clog2(STAT_CHARS)-1:0]  stat_idx_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              main_rd_o,
  output logic [DATA_W-1:0]              stat_rd_o,
  output logic [DATA_W-1:0]              port_o
);
  localparam int unsigned MAIN_DEPTH = NUM_REGS * MAIN_CHARS;
  localparam int unsigned STAT_DEPTH = NUM_REGS * STAT_CHARS;

  logic [DATA_W-1:0] main_q [MAIN_DEPTH];
  logic [DATA_W-1:0] stat_q [STAT_DEPTH];
  logic [DATA_W-1:0] port_q;

  assign main_rd_o = main_q[{reg_i, char_i}];
  assign stat_rd_o = stat_q[{reg_i, stat_idx_i}];
  assign port_o    = port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAIN_DEPTH; i++) main_q[i] <= '0;
    end else if (wr_main_i) begin
      main_q[{reg_i, char_i}] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAT_DEPTH; i++) stat_q[i] <= '0;
    end else if (wr_stat_i) begin
      stat_q[{reg_i, stat_idx_i}] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        port_q <= '0;
    else if (wr_port_i) port_q <= wdata_i;
  end

  AST_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_port_i |=> $stable(port_o)); // R7
  AST_STAT_SPARES_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i |=> $stable(main_rd_o)); // R6
  AST_MAIN_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_main_i |=> main_rd_o == $past(wdata_i)); // R4
endmodule

// File: rtl/nibble_ram.sv
module nibble_ram
  import nibble_ram_pkg::*;
#(
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned NUM_REGS   = 4,
  parameter int unsigned MAIN_CHARS = 16,
  parameter int unsigned STAT_CHARS = 4,
  parameter int unsigned CHIP_ID    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              bank_sel_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] port_o
);
  localparam int unsigned REG_W  = $clog2(NUM_REGS);
  localparam int unsigned CHAR_W = $clog2(MAIN_CHARS);

  phase_e            phase;
  logic              valid;
  logic              wr_main, wr_stat, wr_port, rd_main, rd_stat;
  logic [1:0]        stat_idx;
  logic [REG_W-1:0]  reg_sel;
  logic [CHAR_W-1:0] char_sel;
  logic [DATA_W-1:0] main_rd, stat_rd;

  nibble_ram_phase i_phase (
    .clk_i, .rst_ni, .sync_i,
    .phase_o (phase),
    .valid_o (valid)
  );

  nibble_ram_ctrl #(
    .DATA_W(DATA_W), .REG_W(REG_W), .CHAR_W(CHAR_W), .CHIP_ID(CHIP_ID)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .phase_i    (phase),
    .valid_i    (valid),
    .bank_sel_i,
    .bus_i,
    .wr_main_o  (wr_main),
    .wr_stat_o  (wr_stat),
    .wr_port_o  (wr_port),
    .rd_main_o  (rd_main),
    .rd_stat_o  (rd_stat),
    .stat_idx_o (stat_idx),
    .reg_o      (reg_sel),
    .char_o     (char_sel)
  );

  nibble_ram_store #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .MAIN_CHARS(MAIN_CHARS), .STAT_CHARS(STAT_CHARS)
  ) i_store (
    .clk_i, .rst_ni,
    .wr_main_i  (wr_main),
    .wr_stat_i  (wr_stat),
    .wr_port_i  (wr_port),
    .reg_i      (reg_sel),
    .char_i     (char_sel),
    .stat_idx_i (stat_idx),
    .wdata_i    (bus_i),
    .main_rd_o  (main_rd),
    .stat_rd_o  (stat_rd),
    .port_o
  );

  assign bus_oe_o = rd_main | rd_stat;
  assign bus_o    = rd_main ? main_rd : (rd_stat ? stat_rd : '0);

  AST_OE_X2_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (valid && phase == PH_X2)); // R8
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0); // R8
  AST_NO_WRITE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |=> $stable(port_o)); // R5
endmodule

// File: tb/test_nibble_ram.sv
module test_nibble_ram;
  localparam int CHIP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0, bank = 1'b0;
  logic [3:0] bus_in = '0;
  logic [3:0] bus_out, port;
  logic       oe;

  int compared = 0, mismatched = 0;

  // reference state
  int m_ph;                 // -1 = not locked
  int m_op;
  bit m_act;
  int m_hi, m_addr, m_port;
  int mm [64];
  int st [16];

  always #2.5 clk = ~clk;

  nibble_ram #(.CHIP_ID(CHIP)) i_nibble_ram (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .bank_sel_i(bank),
    .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe), .port_o(port)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_ph = -1; m_op = 0; m_act = 0; m_hi = 0; m_addr = 0; m_port = 0;
    for (int i = 0; i < 64; i++) mm[i] = 0;
    for (int i = 0; i < 16; i++) st[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sync = 0; bank = 0; bus_in = '0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10", "port_o after reset", port, 0);
    chk("R10", "bus_oe_o after reset", oe, 0);
  endtask

  task automatic cyc(input logic s, input logic b, input logic [3:0] d, input string tag);
    int  cur, idx, reg_n;
    bit  hit, exp_oe;
    int  exp_d;
    @(negedge clk);
    sync = s; bank = b; bus_in = d;
    #1;
    cur    = s ? 0 : m_ph;
    hit    = ((m_addr >> 6) & 3) == CHIP;
    reg_n  = (m_addr >> 4) & 3;
    idx    = reg_n * 16 + (m_addr & 15);
    exp_oe = cur == 6 && m_act && hit && (m_op == 2 || (m_op >= 8 && m_op <= 11));
    exp_d  = !exp_oe ? 0 : (m_op == 2 ? mm[idx] : st[reg_n * 4 + (m_op - 8)]);
    chk(tag, "bus_oe_o", oe, exp_oe);
    chk(tag, "bus_o", bus_out, exp_d);
    chk(tag, "port_o", port, m_port);
    if (cur == 4) begin
      m_act = b;
      m_op  = d;
    end else if (cur == 6 && m_act) begin
      if (m_op == 0) m_hi = d;
      else if (hit) begin
        if (m_op == 1) mm[idx] = d;
        else if (m_op == 3) m_port = d;
        else if (m_op >= 4 && m_op <= 7) st[reg_n * 4 + (m_op - 4)] = d;
      end
    end else if (cur == 7 && m_act && m_op == 0) begin
      m_addr = (m_hi << 4) | d;
    end
    m_ph = (cur < 0) ? -1 : (cur + 1) % 8;
  endtask

  task automatic instr(input logic b, input logic [3:0] op, input logic [3:0] x2,
                       input logic [3:0] x3, input string tag);
    cyc(1, 0, 4'h0, tag);
    cyc(0, 0, 4'h5, tag);
    cyc(0, 0, 4'hA, tag);
    cyc(0, 0, 4'h3, tag);
    cyc(0, b, op, tag);
    cyc(0, 0, 4'h0, tag);
    cyc(0, 0, x2, tag);
    cyc(0, 0, x3, tag);
  endtask

  task automatic set_addr(input logic b, input int chip, input int r, input int c, input string tag);
    logic [7:0] a;
    a = 8'((chip << 6) | (r << 4) | c);
    instr(b, 4'h0, a[7:4], a[3:0], tag);
  endtask

  initial begin
    #(5ns * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // R1: traffic before any sync is ignored
    for (int i = 0; i < 24; i++) cyc(0, 1, 4'(i % 3), "R1");

    // R3 / R4 / R5: address then write and read main
    set_addr(1, CHIP, 1, 5, "R3");
    instr(1, 4'h1, 4'hA, 4'h0, "R4");
    instr(1, 4'h2, 4'h0, 4'h0, "R5");

    // R6: status chars of register 1, then main still intact
    for (int n = 0; n < 4; n++) instr(1, 4'(4 + n), 4'(n + 1), 4'h0, "R6");
    for (int n = 0; n < 4; n++) instr(1, 4'(8 + n), 4'h0, 4'h0, "R6");
    instr(1, 4'h2, 4'h0, 4'h0, "R6");
    set_addr(1, CHIP, 1, 12, "R6");
    instr(1, 4'h9, 4'h0, 4'h0, "R6");
    instr(1, 4'h2, 4'h0, 4'h0, "R6");

    // R4 / R5 across registers and characters
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c += 5) begin
        set_addr(1, CHIP, r, c, "R3");
        instr(1, 4'h1, 4'((r * 3 + c + 7) & 15), 4'h0, "R4");
      end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c += 5) begin
        set_addr(1, CHIP, r, c, "R3");
        instr(1, 4'h2, 4'h0, 4'h0, "R5");
      end

    // R2: bank low - no drive, no write, no address change
    set_addr(1, CHIP, 2, 5, "R2");
    instr(0, 4'h2, 4'h0, 4'h0, "R2");
    instr(0, 4'h1, 4'hF, 4'h0, "R2");
    instr(0, 4'h6, 4'hE, 4'h0, "R2");
    set_addr(0, CHIP, 3, 0, "R2");
    instr(1, 4'h2, 4'h0, 4'h0, "R2");
    instr(1, 4'hA, 4'h0, 4'h0, "R2");

    // R7: port latch
    instr(1, 4'h3, 4'h6, 4'h0, "R7");
    instr(1, 4'h2, 4'h0, 4'h0, "R7");
    instr(0, 4'h3, 4'h9, 4'h0, "R7");

    // R9: other chip selected
    set_addr(1, 0, 2, 5, "R9");
    instr(1, 4'h2, 4'h0, 4'h0, "R9");
    instr(1, 4'h1, 4'h3, 4'h0, "R9");
    instr(1, 4'h5, 4'hC, 4'h0, "R9");
    instr(1, 4'h3, 4'hD, 4'h0, "R9");
    set_addr(1, CHIP, 2, 5, "R9");
    instr(1, 4'h2, 4'h0, 4'h0, "R9");
    instr(1, 4'h9, 4'h0, 4'h0, "R9");

    // R11: reserved opcodes
    for (int op = 12; op < 16; op++) instr(1, 4'(op), 4'hB, 4'h0, "R11");
    instr(1, 4'h2, 4'h0, 4'h0, "R11");
    for (int n = 0; n < 4; n++) instr(1, 4'(8 + n), 4'h0, 4'h0, "R11");

    // R1: sync restarts mid-cycle
    cyc(1, 0, 4'h0, "R1");
    cyc(0, 0, 4'h0, "R1");
    cyc(0, 1, 4'h2, "R1");
    instr(1, 4'h2, 4'h0, 4'h0, "R1");

    // R10: reset clears everything
    do_reset();
    for (int i = 0; i < 10; i++) cyc(0, 1, 4'h2, "R10");
    set_addr(1, CHIP, 1, 5, "R10");
    instr(1, 4'h2, 4'h0, 4'h0, "R10");
    for (int n = 0; n < 4; n++) instr(1, 4'(8 + n), 4'h0, 4'h0, "R10");
    set_addr(1, CHIP, 2, 5, "R10");
    instr(1, 4'h2, 4'h0, 4'h0, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule